// File: doc/BRIEF.md
# Three-Phase Edge-Aligned PWM with Mid-Cycle Sample Trigger

This block drives the three phase inputs of a motor bridge from one shared up-counter. All three outputs run at the same period and rise on the same clock. Each phase is commanded by a signed offset, in counter ticks, from a 50% centre duty. A zero offset on every phase makes the three outputs identical, so no differential voltage is applied to the motor. Non-zero offsets move each duty above or below the centre without changing the period. The duty is clamped a small margin away from 0% and 100%, so an external driver's dead time never swallows a pulse.

Once per cycle the block emits a one-clock trigger when the counter reaches half the modulus. This starts a converter sampling the supply-side shunt current in the middle of the cycle, where the phase outputs differ, instead of at the cycle edge. A one-clock cycle-start pulse marks each wrap of the counter. The period and the three offsets are captured into shadow registers only at a wrap, so a change never cuts a pulse short. The modulus is the system clock divided by the PWM rate, for example 1250 for 40 kHz from 50 MHz.

The control is a two-state machine. ST_IDLE holds the counter at zero with every output low. ST_RUN counts and drives the outputs. The transitions are: start (ST_IDLE to ST_RUN, when a valid modulus is present), wrap (ST_RUN to ST_RUN at the end of a cycle with a valid modulus, reloading the shadows) and stop (ST_RUN to ST_IDLE at the end of a cycle when the modulus input is below the minimum).

Top module: `pwm3_ctrig`

## Requirements
- R1: In ST_RUN one cycle lasts exactly the captured modulus in clocks. cycle_start_o is high for exactly one clock per cycle, on the clock where the counter is zero.
- R2: Each phase output is edge-aligned. It is high from counter zero while the counter is below that phase's compare value, and low for the rest of the cycle, with no second high interval.
- R3: A phase's compare value is floor(modulus/2) plus its offset. The offset is a two's-complement count of ticks. Zero offsets on all phases give identical outputs at every clock.
- R4: The sum is first saturated to the range 0 to modulus. It is then clamped to the range lo to (modulus - lo), where lo = floor(modulus/32), which is about 3%.
- R5: sample_trig_o is high for exactly one clock per cycle, when the counter equals floor(modulus/2).
- R6: The modulus and the three offsets are sampled only at the clock that starts a cycle. Changes made mid-cycle affect neither the current duties nor the trigger position.
- R7: If the modulus input is below 8 at the end of a cycle, the block takes the stop transition to ST_IDLE. All outputs then stay low and neither pulse occurs.
- R8: While reset is asserted and directly after it, the block is in ST_IDLE with all five outputs low.
- R9: From ST_IDLE, the first clock edge that sees a modulus of 8 or more starts a cycle. cycle_start_o is high during the following clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| period_i | input | CNT_W | Modulus: PWM period in clocks |
| ofs_a_i | input | OFS_W | Signed duty offset, phase A |
| ofs_b_i | input | OFS_W | Signed duty offset, phase B |
| ofs_c_i | input | OFS_W | Signed duty offset, phase C |
| pwm_a_o | output | 1 | PWM output, phase A |
| pwm_b_o | output | 1 | PWM output, phase B |
| pwm_c_o | output | 1 | PWM output, phase C |
| cycle_start_o | output | 1 | One-clock pulse at counter zero |
| sample_trig_o | output | 1 | One-clock pulse at counter = modulus/2 |

## Verification
The hardest case to reach from the ports is a change that arrives inside a running cycle. It must be held back until the next wrap, both for an offset and for a modulus that would stop the block. The bench synchronises to a cycle_start_o pulse and changes the inputs on that same clock, once the load edge has passed. It then measures the whole current cycle clock by clock and compares it with the old settings. The next cycle is compared with the new settings, or, for the stop case, checked to stay quiet. Saturation and clamping are reached with offsets at both extremes of the signed range and just past each clamp limit. Both an even and an odd modulus are used.

// File: rtl/pwm3_pkg.sv
package pwm3_pkg;
    localparam int NUM_PH = 3;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } pwm3_state_e;
endpackage

// File: rtl/pwm3_timebase.sv
module pwm3_timebase #(
    parameter int CNT_W   = 16,
    parameter int MIN_MOD = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] period_i,
    output logic             load_o,
    output logic             run_o,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] mod_o,
    output logic             cycle_start_o,
    output logic             sample_trig_o
);
    import pwm3_pkg::*;

    localparam logic [CNT_W-1:0] MIN_MOD_V = CNT_W'(MIN_MOD);
    localparam logic [CNT_W-1:0] ONE_V     = CNT_W'(1);

    pwm3_state_e      state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] mod_q;
    logic             mod_ok;
    logic             wrap;
    logic             load;

    assign mod_ok = (period_i >= MIN_MOD_V);
    assign wrap   = (cnt_q == (mod_q - ONE_V));

    // next-state and load decision
    always_comb begin
        state_d = state_q;
        load    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (mod_ok) begin
                    state_d = ST_RUN;   // start
                    load    = 1'b1;
                end
            end
            ST_RUN: begin
                if (wrap) begin
                    if (mod_ok) begin
                        state_d = ST_RUN;   // wrap
                        load    = 1'b1;
                    end else begin
                        state_d = ST_IDLE;  // stop
                    end
                end
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // counter and shadow modulus
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            mod_q <= '0;
        end else begin
            if (load) begin
                cnt_q <= '0;
                mod_q <= period_i;
            end else if (state_q == ST_RUN && !wrap) begin
                cnt_q <= cnt_q + ONE_V;
            end else begin
                cnt_q <= '0;
            end
        end
    end

    // outputs
    always_comb begin
        run_o         = 1'b0;
        cycle_start_o = 1'b0;
        sample_trig_o = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                run_o = 1'b0;
            end
            ST_RUN: begin
                run_o         = 1'b1;
                cycle_start_o = (cnt_q == '0);
                sample_trig_o = (cnt_q == (mod_q >> 1));
            end
        endcase
    end

    assign load_o = load;
    assign cnt_o  = cnt_q;
    assign mod_o  = mod_q;
endmodule

// File: rtl/pwm3_duty_calc.sv
module pwm3_duty_calc #(
    parameter int CNT_W     = 16,
    parameter int OFS_W     = 16,
    parameter int MARGIN_SH = 5
) (
    input  logic [CNT_W-1:0] period_i,
    input  logic [OFS_W-1:0] ofs_i,
    output logic [CNT_W-1:0] cmp_o
);
    localparam int SUM_W = ((CNT_W > OFS_W) ? CNT_W : OFS_W) + 2;

    logic signed [SUM_W-1:0] half_s;
    logic signed [SUM_W-1:0] mod_s;
    logic signed [SUM_W-1:0] ofs_s;
    logic signed [SUM_W-1:0] sum_s;
    logic [CNT_W-1:0]        sat_v;
    logic [CNT_W-1:0]        lo_v;
    logic [CNT_W-1:0]        hi_v;

    always_comb begin
        half_s = $signed({{(SUM_W-CNT_W){1'b0}}, (period_i >> 1)});
        mod_s  = $signed({{(SUM_W-CNT_W){1'b0}}, period_i});
        ofs_s  = $signed({{(SUM_W-OFS_W){ofs_i[OFS_W-1]}}, ofs_i});
        sum_s  = half_s + ofs_s;

        // saturate to 0 .. modulus
        if (sum_s < 0) begin
            sat_v = '0;
        end else if (sum_s > mod_s) begin
            sat_v = period_i;
        end else begin
            sat_v = sum_s[CNT_W-1:0];
        end

        // clamp away from both extremes
        lo_v = period_i >> MARGIN_SH;
        hi_v = period_i - lo_v;
        if (sat_v < lo_v) begin
            cmp_o = lo_v;
        end else if (sat_v > hi_v) begin
            cmp_o = hi_v;
        end else begin
            cmp_o = sat_v;
        end
    end
endmodule

// File: rtl/pwm3_phase.sv
module pwm3_phase #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic             run_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic [CNT_W-1:0] cmp_next_i,
    output logic [CNT_W-1:0] cmp_o,
    output logic             pwm_o
);
    logic [CNT_W-1:0] cmp_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmp_q <= '0;
        end else if (load_i) begin
            cmp_q <= cmp_next_i;
        end
    end

    assign pwm_o = run_i && (cnt_i < cmp_q);
    assign cmp_o = cmp_q;
endmodule

// File: rtl/pwm3_ctrig.sv
module pwm3_ctrig #(
    parameter int CNT_W     = 16,
    parameter int OFS_W     = 16,
    parameter int MIN_MOD   = 8,
    parameter int MARGIN_SH = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] period_i,
    input  logic [OFS_W-1:0] ofs_a_i,
    input  logic [OFS_W-1:0] ofs_b_i,
    input  logic [OFS_W-1:0] ofs_c_i,
    output logic             pwm_a_o,
    output logic             pwm_b_o,
    output logic             pwm_c_o,
    output logic             cycle_start_o,
    output logic             sample_trig_o
);
    import pwm3_pkg::*;

    logic                              load;
    logic                              run;
    logic [CNT_W-1:0]                  cnt;
    logic [CNT_W-1:0]                  mod_q;
    logic [NUM_PH-1:0][OFS_W-1:0]      ofs_vec;
    logic [NUM_PH-1:0][CNT_W-1:0]      cmp_next;
    logic [NUM_PH-1:0][CNT_W-1:0]      cmp_q;
    logic [NUM_PH-1:0]                 pwm;

    assign ofs_vec = {ofs_c_i, ofs_b_i, ofs_a_i};

    pwm3_timebase #(
        .CNT_W   (CNT_W),
        .MIN_MOD (MIN_MOD)
    ) u_tbase (
        .clk           (clk),
        .rst_n         (rst_n),
        .period_i      (period_i),
        .load_o        (load),
        .run_o         (run),
        .cnt_o         (cnt),
        .mod_o         (mod_q),
        .cycle_start_o (cycle_start_o),
        .sample_trig_o (sample_trig_o)
    );

    for (genvar p = 0; p < NUM_PH; p++) begin : g_ph
        pwm3_duty_calc #(
            .CNT_W     (CNT_W),
            .OFS_W     (OFS_W),
            .MARGIN_SH (MARGIN_SH)
        ) u_calc (
            .period_i (period_i),
            .ofs_i    (ofs_vec[p]),
            .cmp_o    (cmp_next[p])
        );

        pwm3_phase #(
            .CNT_W (CNT_W)
        ) u_phase (
            .clk        (clk),
            .rst_n      (rst_n),
            .load_i     (load),
            .run_i      (run),
            .cnt_i      (cnt),
            .cmp_next_i (cmp_next[p]),
            .cmp_o      (cmp_q[p]),
            .pwm_o      (pwm[p])
        );
    end

    assign pwm_a_o = pwm[0];
    assign pwm_b_o = pwm[1];
    assign pwm_c_o = pwm[2];
endmodule

// File: rtl/pwm3_ctrig_chk.sv
module pwm3_ctrig_chk #(
    parameter int CNT_W     = 16,
    parameter int MARGIN_SH = 5
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   run,
    input logic [CNT_W-1:0]       mod_q,
    input logic [2:0][CNT_W-1:0]  cmp_q,
    input logic [2:0]             pwm,
    input logic                   cycle_start_o,
    input logic                   sample_trig_o
);
    assert_start_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cycle_start_o |=> !cycle_start_o);

    assert_high_at_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cycle_start_o && mod_q >= CNT_W'(32)) |-> (pwm == 3'b111));

    assert_trig_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        sample_trig_o |=> !sample_trig_o);

    assert_trig_apart_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(sample_trig_o && cycle_start_o));

    assert_shadow_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !cycle_start_o |-> $stable(cmp_q));

    assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> (pwm == 3'b000 && !cycle_start_o && !sample_trig_o));

    for (genvar p = 0; p < 3; p++) begin : g_bound
        assert_cmp_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
            run |-> (cmp_q[p] >= (mod_q >> MARGIN_SH) &&
                     cmp_q[p] <= (mod_q - (mod_q >> MARGIN_SH))));
    end
endmodule

bind pwm3_ctrig pwm3_ctrig_chk #(
    .CNT_W     (CNT_W),
    .MARGIN_SH (MARGIN_SH)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .run           (run),
    .mod_q         (mod_q),
    .cmp_q         (cmp_q),
    .pwm           (pwm),
    .cycle_start_o (cycle_start_o),
    .sample_trig_o (sample_trig_o)
);

// File: tb/pwm3_ctrig_tb_top.sv
`timescale 1ns/1ps
module pwm3_ctrig_tb_top;
    localparam int CNT_W = 16;
    localparam int OFS_W = 16;
    localparam int NV    = 8;

    // columns: modulus, ofs A, ofs B, ofs C, high A, high B, high C, trigger position
    localparam int VEC [NV][8] = '{
        '{ 64,     0,      0,   0,  32,  32,  32, 32},
        '{ 64,     5,     -5,  10,  37,  27,  42, 32},
        '{ 64,    40,    -40,   0,  62,   2,  32, 32},
        '{ 64,    30,    -30,  31,  62,   2,  62, 32},
        '{100,     0,     47, -48,  50,  97,   3, 50},
        '{101,     0,     -1,   1,  50,  49,  51, 50},
        '{200, 32767, -32768,   0, 194,   6, 100, 100},
        '{ 40,   -19,     19, -20,   1,  39,   1, 20}
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [CNT_W-1:0] period_i = 16'd64;
    logic [OFS_W-1:0] ofs_a_i = '0;
    logic [OFS_W-1:0] ofs_b_i = '0;
    logic [OFS_W-1:0] ofs_c_i = '0;
    logic             pwm_a_o, pwm_b_o, pwm_c_o;
    logic             cycle_start_o, sample_trig_o;

    int n_chk = 0;
    int n_err = 0;
    int cyc   = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    pwm3_ctrig dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .period_i      (period_i),
        .ofs_a_i       (ofs_a_i),
        .ofs_b_i       (ofs_b_i),
        .ofs_c_i       (ofs_c_i),
        .pwm_a_o       (pwm_a_o),
        .pwm_b_o       (pwm_b_o),
        .pwm_c_o       (pwm_c_o),
        .cycle_start_o (cycle_start_o),
        .sample_trig_o (sample_trig_o)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // must be called at a negedge where cycle_start_o is high; returns at the next one
    task automatic measure(output int per, output int ha, output int hb, output int hc,
                           output int tpos, output int tcnt, output int shape);
        bit lo_a = 0, lo_b = 0, lo_c = 0;
        int n = 0;
        ha = 0; hb = 0; hc = 0; tpos = -1; tcnt = 0; shape = 0;
        do begin
            if (pwm_a_o) begin ha++; if (lo_a) shape++; end else lo_a = 1;
            if (pwm_b_o) begin hb++; if (lo_b) shape++; end else lo_b = 1;
            if (pwm_c_o) begin hc++; if (lo_c) shape++; end else lo_c = 1;
            if (sample_trig_o) begin tcnt++; tpos = n; end
            n++;
            @(negedge clk);
        end while (!cycle_start_o);
        per = n;
    endtask

    task automatic sync_start();
        while (cycle_start_o) @(negedge clk);
        while (!cycle_start_o) @(negedge clk);
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000 && !done) begin
            done = 1'b1;
            n_chk++;
            n_err++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        int per, ha, hb, hc, tpos, tcnt, shape;

        // R8: reset state
        repeat (3) @(negedge clk);
        check({pwm_a_o, pwm_b_o, pwm_c_o, cycle_start_o, sample_trig_o} == 5'b0,
              "R8 outputs in reset", {pwm_a_o, pwm_b_o, pwm_c_o, cycle_start_o, sample_trig_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R9: first edge with a valid modulus starts a cycle
        check(cycle_start_o == 1'b1, "R9 start after reset", cycle_start_o, 1);

        // table walk
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            period_i = CNT_W'(VEC[i][0]);
            ofs_a_i  = OFS_W'(VEC[i][1]);
            ofs_b_i  = OFS_W'(VEC[i][2]);
            ofs_c_i  = OFS_W'(VEC[i][3]);
            sync_start();
            measure(per, ha, hb, hc, tpos, tcnt, shape);
            check(per == VEC[i][0], "R1 period", per, VEC[i][0]);
            check(ha == VEC[i][4], "R3 R4 duty A", ha, VEC[i][4]);
            check(hb == VEC[i][5], "R3 R4 duty B", hb, VEC[i][5]);
            check(hc == VEC[i][6], "R3 R4 duty C", hc, VEC[i][6]);
            check(shape == 0, "R2 single high interval", shape, 0);
            check(tcnt == 1, "R5 trigger count", tcnt, 1);
            check(tpos == VEC[i][7], "R5 trigger position", tpos, VEC[i][7]);
        end

        // R6: offset changed during a cycle takes effect only at the next one
        @(negedge clk);
        period_i = 16'd64; ofs_a_i = '0; ofs_b_i = '0; ofs_c_i = '0;
        sync_start();
        ofs_a_i = 16'd20;
        period_i = 16'd80;
        measure(per, ha, hb, hc, tpos, tcnt, shape);
        check(ha == 32, "R6 old duty kept", ha, 32);
        check(per == 64, "R6 old period kept", per, 64);
        check(tpos == 32, "R6 old trigger kept", tpos, 32);
        measure(per, ha, hb, hc, tpos, tcnt, shape);
        check(ha == 60, "R6 new duty applied", ha, 60);
        check(per == 80, "R6 new period applied", per, 80);
        check(hb == hc && hb == 40, "R3 zero offset centre", hb, 40);

        // R7: modulus below minimum stops the block at the wrap
        @(negedge clk);
        period_i = 16'd64; ofs_a_i = '0;
        sync_start();
        period_i = 16'd4;
        begin
            int trig_seen = 0;
            int busy = 0;
            for (int k = 0; k < 64; k++) begin
                if (k == 32 && sample_trig_o) trig_seen = 1;
                @(negedge clk);
            end
            check(trig_seen == 1, "R6 trigger kept in final cycle", trig_seen, 1);
            for (int k = 0; k < 100; k++) begin
                if (pwm_a_o || pwm_b_o || pwm_c_o || cycle_start_o || sample_trig_o) busy++;
                @(negedge clk);
            end
            check(busy == 0, "R7 idle outputs quiet", busy, 0);
        end

        // R9: restart one clock after a valid modulus appears
        period_i = 16'd64;
        @(negedge clk);
        check(cycle_start_o == 1'b1, "R9 restart timing", cycle_start_o, 1);
        measure(per, ha, hb, hc, tpos, tcnt, shape);
        check(per == 64 && ha == 32, "R1 R9 cycle after restart", ha, 32);

        // R8: reset mid-cycle returns to idle
        repeat (10) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check({pwm_a_o, pwm_b_o, pwm_c_o, cycle_start_o, sample_trig_o} == 5'b0,
              "R8 reset mid-cycle", {pwm_a_o, pwm_b_o, pwm_c_o, cycle_start_o, sample_trig_o}, 0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
        $finish;
    end
endmodule